// File: doc/BRIEF.md
# Integer-N Synthesizer Counting and Phase Comparison Core

This block is the digital heart of an integer-N frequency synthesizer. It runs on one system clock and receives two single-cycle event strobes: one for each edge of the RF signal after the analog preamplifier, and one for each edge of the reference source. A 17-bit main counter divides the RF events, optionally behind a divide-by-two stage. A reference counter divides the reference events by one of sixteen ratios. The two divided event streams meet in a two-flop phase-frequency comparator whose up and down flags drive an external charge pump.

A lock monitor watches how long the comparator flags differ in each comparison and raises an in-lock flag after a run of tight comparisons. A registered clock output can carry the reference strobe, the divided comparison strobe, or nothing. A monitor mode places the main counter output divided by two on a general-purpose port. For alignment, the pump outputs can be forced up, down or off, and the external driver can be released.

Top module: `synth_divider_core`

## Requirements
- R1: With the prescaler off, `div_tick` pulses for one cycle once every N RF strobes, where N is `main_ratio`. Values 0 and 1 are treated as 2. `div_tick` is registered, so it appears one cycle after the strobe that ends the period.
- R2: With `presc_en` set, every second RF strobe is counted, so `div_tick` comes once every 2N RF strobes.
- R3: `comp_tick` pulses once every R reference strobes. R is chosen by `ref_sel` (0..15) from 2, 4, 8, 16, 24, 32, 40, 48, 64, 80, 96, 128, 160, 192, 256, 320, in that index order.
- R4: A new `main_ratio`, `presc_en` or `ref_sel` takes effect only at the next terminal count. The period already running ends at its old length. After reset, both counters end their first period on the first qualifying strobe.
- R5: The comparator sets `up` the cycle after `comp_tick` and sets `dn` the cycle after `div_tick`. Once both are high, both clear on the next cycle. Coincident ticks give both outputs high for exactly one cycle. A reference lead of k cycles keeps `pump_up` high for k+1 cycles and `pump_dn` high for 1 cycle.
- R6: A comparison ends on a cycle where both flags are high. If the number of cycles with exactly one flag high in that comparison is at most PHASE_TOL (2), the comparison is good. `lock` rises one cycle after the 8th consecutive good comparison. It falls one cycle after the first bad one, and it is low from reset.
- R7: `clkout_sel` 1 makes `ref_out` the reference strobe delayed by one cycle. A value of 2 makes it `comp_tick` delayed by one cycle (two cycles after the strobe). Values 0 and 3 hold it low.
- R8: `cp_test` 0 passes the comparator flags. A value of 1 forces `pump_up`=1 and `pump_dn`=0, 2 forces `pump_up`=0 and `pump_dn`=1, and 3 forces both to 0, all in the same cycle. `drive_en` is the inverse of `drive_release`.
- R9: With `div_monitor_en` set, `port0_out` is a flop that toggles on every `div_tick` and is visible one cycle after it. Otherwise `port0_out` follows `port0_level`.
- R10: During reset, `pump_up`, `pump_dn`, `lock`, `ref_out`, `div_tick` and `comp_tick` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rf_pulse | input | 1 | One-cycle strobe per RF edge |
| xtal_pulse | input | 1 | One-cycle strobe per reference edge |
| main_ratio | input | 17 | Main division ratio N |
| presc_en | input | 1 | Insert divide-by-two ahead of the main counter |
| ref_sel | input | 4 | Reference ratio index |
| clkout_sel | input | 2 | Clock output source: 0/3 off, 1 reference, 2 comparison |
| cp_test | input | 2 | Pump test mode: 0 normal, 1 up, 2 down, 3 off |
| drive_release | input | 1 | Release the external driver |
| div_monitor_en | input | 1 | Put half the main counter output on port 0 |
| port0_level | input | 1 | General-purpose level for port 0 |
| pump_up | output | 1 | Charge pump up request |
| pump_dn | output | 1 | Charge pump down request |
| lock | output | 1 | In-lock flag |
| ref_out | output | 1 | Selected clock output |
| port0_out | output | 1 | Port 0 output |
| drive_en | output | 1 | External driver enable |
| div_tick | output | 1 | Main counter terminal pulse |
| comp_tick | output | 1 | Reference counter terminal pulse |

## Verification
`div_tick`, `comp_tick` and the one-source `ref_out` appear one cycle after the strobe that causes them. The comparator flags appear one cycle after their tick, which makes them two cycles after the strobe, and `ref_out` in comparison mode also lands two cycles after the strobe. `lock` and the monitor port change one cycle after the comparison or tick that causes them. The pump forcing is combinational. The bench drives inputs and samples outputs on falling edges and counts exactly these register stages before each comparison. Divider ratios are measured as the distance between ticks, after one tick has passed so that newly applied settings are in effect.

// File: rtl/synth_core_pkg.sv
package synth_core_pkg;

  localparam int REF_RATIO_W = 9;

  typedef enum logic [1:0] {
    CLKOUT_OFF  = 2'd0,
    CLKOUT_XTAL = 2'd1,
    CLKOUT_COMP = 2'd2,
    CLKOUT_NONE = 2'd3
  } clkout_sel_e;

  typedef enum logic [1:0] {
    PUMP_NORMAL    = 2'd0,
    PUMP_FORCE_UP  = 2'd1,
    PUMP_FORCE_DN  = 2'd2,
    PUMP_FORCE_OFF = 2'd3
  } pump_test_e;

  // Reference ratio lookup, indexed by the 4-bit selector (R3)
  function automatic logic [REF_RATIO_W-1:0] ref_ratio(input logic [3:0] idx);
    logic [REF_RATIO_W-1:0] r;
    case (idx)
      4'd0:  r = 9'd2;
      4'd1:  r = 9'd4;
      4'd2:  r = 9'd8;
      4'd3:  r = 9'd16;
      4'd4:  r = 9'd24;
      4'd5:  r = 9'd32;
      4'd6:  r = 9'd40;
      4'd7:  r = 9'd48;
      4'd8:  r = 9'd64;
      4'd9:  r = 9'd80;
      4'd10: r = 9'd96;
      4'd11: r = 9'd128;
      4'd12: r = 9'd160;
      4'd13: r = 9'd192;
      4'd14: r = 9'd256;
      default: r = 9'd320;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/synth_period_counter.sv
module synth_period_counter #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] load_val,
  output logic         wrap,
  output logic         tick
);

  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] MIN_RATIO = W'(2);

  logic [W-1:0] cnt;

  // ratios below two would make the period degenerate (R1)
  function automatic logic [W-1:0] clamp_ratio(input logic [W-1:0] n);
    return (n < MIN_RATIO) ? MIN_RATIO : n;
  endfunction

  assign wrap = step && (cnt == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= ONE;
      tick <= 1'b0;
    end else begin
      tick <= wrap;
      if (wrap)
        cnt <= clamp_ratio(load_val);   // new ratio only at terminal count (R4)
      else if (step)
        cnt <= cnt - ONE;
    end
  end

  a_r1_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  a_r4_hold_between_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (!step) |=> $stable(cnt));

endmodule

// File: rtl/synth_main_div.sv
module synth_main_div #(
  parameter int DIV_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rf_pulse,
  input  logic [DIV_W-1:0] ratio,
  input  logic             presc_en,
  output logic             div_tick
);

  logic presc_q;   // prescaler setting in effect for the running period
  logic half_ph;   // prescaler phase
  logic adv;       // qualified count event
  logic wrap;

  assign adv = rf_pulse && (!presc_q || half_ph);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= 1'b0;
      half_ph <= 1'b0;
    end else begin
      if (wrap)
        presc_q <= presc_en;            // R4
      if (!presc_q)
        half_ph <= 1'b0;
      else if (rf_pulse)
        half_ph <= ~half_ph;            // R2
    end
  end

  synth_period_counter #(.W(DIV_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (adv),
    .load_val (ratio),
    .wrap     (wrap),
    .tick     (div_tick)
  );

  a_r2_skip_odd: assert property (@(posedge clk) disable iff (!rst_n)
    (presc_q && rf_pulse && !half_ph) |-> !wrap);

  a_r4_presc_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap) |=> $stable(presc_q));

endmodule

// File: rtl/synth_pfd.sv
module synth_pfd (
  input  logic clk,
  input  logic rst_n,
  input  logic comp_tick,
  input  logic div_tick,
  output logic up,
  output logic dn
);

  logic both;
  assign both = up && dn;

  // reset feedback: once both are set, clear; ticks landing in that cycle restart
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else if (both) begin
      up <= comp_tick;
      dn <= div_tick;
    end else begin
      up <= up | comp_tick;
      dn <= dn | div_tick;
    end
  end

  a_r5_comp_seen: assert property (@(posedge clk) disable iff (!rst_n)
    comp_tick |=> up);

  a_r5_div_seen: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |=> dn);

  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    (both && !comp_tick && !div_tick) |=> (!up && !dn));

endmodule

// File: rtl/synth_lock_det.sv
module synth_lock_det #(
  parameter int LOCK_COUNT = 8,
  parameter int PHASE_TOL  = 2,
  parameter int ERR_W      = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up,
  input  logic dn,
  output logic lock
);

  localparam int GOOD_W = $clog2(LOCK_COUNT + 1);
  localparam logic [ERR_W-1:0]  ERR_MAX  = {ERR_W{1'b1}};
  localparam logic [GOOD_W-1:0] GOOD_MAX = GOOD_W'(LOCK_COUNT);

  logic [ERR_W-1:0]  err_cnt;
  logic [GOOD_W-1:0] good_cnt;
  logic cmp_done;
  logic within_tol;

  assign cmp_done   = up && dn;
  assign within_tol = (err_cnt <= ERR_W'(PHASE_TOL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_cnt  <= '0;
      good_cnt <= '0;
      lock     <= 1'b0;
    end else if (cmp_done) begin
      err_cnt <= '0;
      if (within_tol) begin
        if (good_cnt != GOOD_MAX)
          good_cnt <= good_cnt + 1'b1;
        lock <= (good_cnt >= GOOD_W'(LOCK_COUNT - 1));
      end else begin
        good_cnt <= '0;
        lock     <= 1'b0;
      end
    end else if ((up ^ dn) && (err_cnt != ERR_MAX)) begin
      err_cnt <= err_cnt + 1'b1;
    end
  end

  a_r6_rise_on_compare: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(cmp_done));

  a_r6_fall_on_compare: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock) |-> $past(cmp_done));

endmodule

// File: rtl/synth_divider_core.sv
module synth_divider_core
  import synth_core_pkg::*;
#(
  parameter int DIV_W      = 17,
  parameter int LOCK_COUNT = 8,
  parameter int PHASE_TOL  = 2,
  parameter int ERR_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rf_pulse,
  input  logic             xtal_pulse,
  input  logic [DIV_W-1:0] main_ratio,
  input  logic             presc_en,
  input  logic [3:0]       ref_sel,
  input  logic [1:0]       clkout_sel,
  input  logic [1:0]       cp_test,
  input  logic             drive_release,
  input  logic             div_monitor_en,
  input  logic             port0_level,
  output logic             pump_up,
  output logic             pump_dn,
  output logic             lock,
  output logic             ref_out,
  output logic             port0_out,
  output logic             drive_en,
  output logic             div_tick,
  output logic             comp_tick
);

  logic ref_wrap;
  logic pfd_up, pfd_dn;
  logic half_q;
  logic ref_src;
  logic clkout_off;

  synth_main_div #(.DIV_W(DIV_W)) u_main (
    .clk      (clk),
    .rst_n    (rst_n),
    .rf_pulse (rf_pulse),
    .ratio    (main_ratio),
    .presc_en (presc_en),
    .div_tick (div_tick)
  );

  synth_period_counter #(.W(REF_RATIO_W)) u_ref (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (xtal_pulse),
    .load_val (ref_ratio(ref_sel)),
    .wrap     (ref_wrap),
    .tick     (comp_tick)
  );

  synth_pfd u_pfd (
    .clk       (clk),
    .rst_n     (rst_n),
    .comp_tick (comp_tick),
    .div_tick  (div_tick),
    .up        (pfd_up),
    .dn        (pfd_dn)
  );

  synth_lock_det #(
    .LOCK_COUNT (LOCK_COUNT),
    .PHASE_TOL  (PHASE_TOL),
    .ERR_W      (ERR_W)
  ) u_lock (
    .clk   (clk),
    .rst_n (rst_n),
    .up    (pfd_up),
    .dn    (pfd_dn),
    .lock  (lock)
  );

  // pump test forcing (R8)
  always_comb begin
    case (pump_test_e'(cp_test))
      PUMP_FORCE_UP:  {pump_up, pump_dn} = 2'b10;
      PUMP_FORCE_DN:  {pump_up, pump_dn} = 2'b01;
      PUMP_FORCE_OFF: {pump_up, pump_dn} = 2'b00;
      default:        {pump_up, pump_dn} = {pfd_up, pfd_dn};
    endcase
  end

  assign drive_en = ~drive_release;

  // clock output source (R7)
  always_comb begin
    case (clkout_sel_e'(clkout_sel))
      CLKOUT_XTAL: ref_src = xtal_pulse;
      CLKOUT_COMP: ref_src = comp_tick;
      default:     ref_src = 1'b0;
    endcase
  end
  assign clkout_off = (clkout_sel == CLKOUT_OFF) || (clkout_sel == CLKOUT_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_out <= 1'b0;
      half_q  <= 1'b0;
    end else begin
      ref_out <= ref_src;
      if (div_tick)
        half_q <= ~half_q;              // R9
    end
  end

  assign port0_out = div_monitor_en ? half_q : port0_level;

  a_r7_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    clkout_off |=> !ref_out);

  a_r8_forced_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_test != 2'd0) |-> !(pump_up && pump_dn));

  a_r9_half_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |=> (half_q != $past(half_q)));

  a_r3_ref_wrap_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ref_wrap |=> comp_tick);

endmodule

// File: tb/synth_divider_core_tb.sv
module synth_divider_core_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rf_pulse = 1'b0, xtal_pulse = 1'b0;
  logic [16:0] main_ratio = 17'd4;
  logic        presc_en = 1'b0;
  logic [3:0]  ref_sel = 4'd1;
  logic [1:0]  clkout_sel = 2'd0, cp_test = 2'd0;
  logic        drive_release = 1'b0, div_monitor_en = 1'b0, port0_level = 1'b0;
  logic        pump_up, pump_dn, lock, ref_out, port0_out, drive_en, div_tick, comp_tick;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;   // 250 MHz

  synth_divider_core dut_i (
    .clk(clk), .rst_n(rst_n), .rf_pulse(rf_pulse), .xtal_pulse(xtal_pulse),
    .main_ratio(main_ratio), .presc_en(presc_en), .ref_sel(ref_sel),
    .clkout_sel(clkout_sel), .cp_test(cp_test), .drive_release(drive_release),
    .div_monitor_en(div_monitor_en), .port0_level(port0_level),
    .pump_up(pump_up), .pump_dn(pump_dn), .lock(lock), .ref_out(ref_out),
    .port0_out(port0_out), .drive_en(drive_en), .div_tick(div_tick),
    .comp_tick(comp_tick)
  );

  // vector: {expected comparison gap[9:0], presc, ref index[3:0], N[16:0]}
  localparam int NVEC = 6;
  localparam logic [31:0] VECS [NVEC] = '{
    {10'd2,   1'b0, 4'd0,  17'd3},
    {10'd24,  1'b1, 4'd4,  17'd7},
    {10'd320, 1'b0, 4'd15, 17'd10},
    {10'd80,  1'b1, 4'd9,  17'd2},
    {10'd16,  1'b0, 4'd3,  17'd1},
    {10'd192, 1'b0, 4'd13, 17'd100}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // counts falling edges until the chosen tick is seen
  task automatic gap_to_tick(input bit use_div, output int gap);
    int c = 0;
    do begin
      @(negedge clk);
      c++;
    end while (!(use_div ? div_tick : comp_tick) && c < 5000);
    gap = c;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int g;
    int k;
    int ups;
    int dns;
    bit prev_both;
    logic p;

    // R10: reset state
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(!pump_up && !pump_dn && !lock && !ref_out && !div_tick && !comp_tick,
          "R10 reset outputs", {pump_up, pump_dn, lock, ref_out, div_tick, comp_tick}, 0);
    rst_n = 1'b1;

    // R1 R2 R3: ratio table walk with strobes on every cycle
    rf_pulse = 1'b1;
    xtal_pulse = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      int n;
      int expd;
      main_ratio = VECS[v][16:0];
      ref_sel    = VECS[v][20:17];
      presc_en   = VECS[v][21];
      n = (VECS[v][16:0] < 2) ? 2 : int'(VECS[v][16:0]);
      expd = VECS[v][21] ? 2 * n : n;
      gap_to_tick(1'b1, g);
      gap_to_tick(1'b1, g);
      gap_to_tick(1'b1, g);
      check(g == expd, VECS[v][21] ? "R2 prescaled main gap" : "R1 main gap", g, expd);
      gap_to_tick(1'b0, g);
      gap_to_tick(1'b0, g);
      check(g == int'(VECS[v][31:22]), "R3 reference gap", g, int'(VECS[v][31:22]));
    end

    // R4: ratio change mid-period completes the old period first
    presc_en = 1'b0;
    main_ratio = 17'd6;
    gap_to_tick(1'b1, g);
    gap_to_tick(1'b1, g);
    main_ratio = 17'd9;
    gap_to_tick(1'b1, g);
    check(g == 6, "R4 old period kept", g, 6);
    gap_to_tick(1'b1, g);
    check(g == 9, "R4 new period applied", g, 9);

    // R6: lock timing with coincident ticks
    rf_pulse = 1'b0;
    xtal_pulse = 1'b0;
    main_ratio = 17'd4;
    ref_sel = 4'd1;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rf_pulse = 1'b1;
    xtal_pulse = 1'b1;
    rst_n = 1'b1;
    k = 0;
    prev_both = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (prev_both && k == 7) check(lock == 1'b0, "R6 no lock after 7", lock, 0);
      if (prev_both && k == 8) check(lock == 1'b1, "R6 lock after 8", lock, 1);
      prev_both = pump_up && pump_dn;
      if (prev_both) k++;
    end
    check(lock == 1'b1, "R6 lock held", lock, 1);

    // R9: monitor port toggles one cycle after div_tick
    div_monitor_en = 1'b1;
    gap_to_tick(1'b1, g);
    p = port0_out;
    @(negedge clk);
    check(port0_out == ~p, "R9 monitor toggle", port0_out, ~p);
    div_monitor_en = 1'b0;
    port0_level = 1'b1;
    @(negedge clk);
    check(port0_out == 1'b1, "R9 plain port level", port0_out, 1);

    // R6: loss of lock when ratios disagree
    main_ratio = 17'd5;
    k = 0;
    while (lock && k < 400) begin
      @(negedge clk);
      k++;
    end
    check(lock == 1'b0, "R6 lock lost", lock, 0);

    // R5: coincident ticks
    rf_pulse = 1'b0;
    xtal_pulse = 1'b0;
    do_reset();
    rf_pulse = 1'b1;
    xtal_pulse = 1'b1;
    @(negedge clk);
    rf_pulse = 1'b0;
    xtal_pulse = 1'b0;
    ups = 0;
    dns = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      ups += pump_up;
      dns += pump_dn;
    end
    check(ups == 1 && dns == 1, "R5 coincident min width", ups * 10 + dns, 11);

    // R5: reference leads by 3 cycles
    do_reset();
    xtal_pulse = 1'b1;
    @(negedge clk);
    xtal_pulse = 1'b0;
    ups = pump_up;
    dns = pump_dn;
    repeat (2) begin
      @(negedge clk);
      ups += pump_up;
      dns += pump_dn;
    end
    rf_pulse = 1'b1;
    @(negedge clk);
    rf_pulse = 1'b0;
    ups += pump_up;
    dns += pump_dn;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      ups += pump_up;
      dns += pump_dn;
    end
    check(ups == 4, "R5 lead up width", ups, 4);
    check(dns == 1, "R5 lead dn width", dns, 1);

    // R8: pump forcing and driver release
    cp_test = 2'd1;
    @(negedge clk);
    check(pump_up && !pump_dn, "R8 force up", {pump_up, pump_dn}, 2);
    cp_test = 2'd2;
    @(negedge clk);
    check(!pump_up && pump_dn, "R8 force down", {pump_up, pump_dn}, 1);
    cp_test = 2'd3;
    @(negedge clk);
    check(!pump_up && !pump_dn, "R8 force off", {pump_up, pump_dn}, 0);
    cp_test = 2'd0;
    drive_release = 1'b1;
    @(negedge clk);
    check(drive_en == 1'b0, "R8 driver released", drive_en, 0);
    drive_release = 1'b0;
    @(negedge clk);
    check(drive_en == 1'b1, "R8 driver enabled", drive_en, 1);

    // R7: reference source
    clkout_sel = 2'd1;
    do_reset();
    xtal_pulse = 1'b1;
    @(negedge clk);
    xtal_pulse = 1'b0;
    check(ref_out == 1'b1, "R7 xtal source delay", ref_out, 1);
    @(negedge clk);
    check(ref_out == 1'b0, "R7 xtal source width", ref_out, 0);

    clkout_sel = 2'd2;
    do_reset();
    xtal_pulse = 1'b1;
    @(negedge clk);
    xtal_pulse = 1'b0;
    check(ref_out == 1'b0, "R7 comp source not early", ref_out, 0);
    @(negedge clk);
    check(ref_out == 1'b1, "R7 comp source delay", ref_out, 1);

    clkout_sel = 2'd0;
    xtal_pulse = 1'b1;
    k = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      k += ref_out;
    end
    check(k == 0, "R7 output off", k, 0);
    clkout_sel = 2'd3;
    k = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      k += ref_out;
    end
    check(k == 0, "R7 output off code 3", k, 0);
    xtal_pulse = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule